// File: doc/BRIEF.md
# Nibble Accumulator Execution Unit

This block carries out the data-path half of a small 4-bit controller's instruction set. It covers the accumulator, carry and RAM-data operations. It holds the working registers: a 4-bit accumulator, a carry flag, a carry-save flag and the 2-bit upper field of the data pointer. The lower pointer field comes in from outside, and the two fields together form the RAM address. Each cycle in which `exec_en` is high, the block decodes one opcode byte. It reads the nibble at the current address and updates its registers on the rising clock edge. In the same cycle it may raise a RAM write and a skip strobe.

The skip strobe tells the surrounding sequencer to discard the next instruction. Arithmetic outcomes reach the program flow through this strobe and not through branch flags. Load and exchange opcodes carry a 2-bit immediate in their low bits. That immediate toggles the pointer upper field after the access, so a program can step between RAM banks while it moves data. The RAM array, the program counter and all I/O sit outside the block.

Top module: `nib_exec_unit`

## Requirements
- R1: A synchronous reset clears the accumulator, carry, carry-save and pointer upper field to zero.
- R2: While `exec_en` is low, no register changes and both `ram_we` and `skip` stay low, whatever the opcode.
- R3: Opcode 0x9n loads the accumulator with n, so 0x90 clears it.
- R4: 0x10 replaces the accumulator with its bitwise inverse. 0x11 replaces it with its two's complement, and 0 stays 0.
- R5: 0x0D adds one to the accumulator and skips when it wraps from F to 0. 0x0F subtracts one and skips when it wraps from 0 to F. Neither touches carry.
- R6: 0x0B clears carry, 0x1B sets carry, and 0x1A swaps carry with carry-save.
- R7: 0x30 shifts the accumulator right by one. The old carry enters bit 3 and the old bit 0 becomes carry.
- R8: 0x1D writes RAM+1 back and skips when the result is 0. 0x1F writes RAM-1 back and skips when the result is F. The accumulator and carry are kept.
- R9: 0x08 sets the accumulator to accumulator+RAM modulo 16 and skips on carry out, with carry unchanged.
- R10: 0x09 and 0x19 add RAM plus carry to the accumulator and load carry with the carry out. Only 0x09 skips on carry out.
- R11: 0x06 adds 6 and 0x0A adds 10 to the accumulator modulo 16, with no carry change and no skip.
- R12: 0x18 XORs RAM into the accumulator. 0x02 writes the accumulator to RAM and leaves it in place.
- R13: 0x38+k loads the accumulator from RAM and 0x28+k swaps it with RAM, for k in 0..3. The access uses the old pointer, and the upper field is then XORed with k.
- R14: Any other opcode (for example 0x2C, 0x4F, 0xC3) changes no register and raises neither `ram_we` nor `skip`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| exec_en | input | 1 | Execute the opcode on this edge |
| opcode | input | 8 | Opcode byte |
| ptr_lo | input | 4 | Lower data-pointer field |
| ram_rd | input | 4 | Nibble read at `ram_addr` |
| ram_addr | output | 6 | RAM address, upper field above lower field |
| ram_we | output | 1 | RAM write strobe for this edge |
| ram_wdata | output | 4 | RAM write data |
| skip | output | 1 | Discard the next instruction |
| acc | output | 4 | Accumulator |
| carry | output | 1 | Carry flag |
| carry_save | output | 1 | Carry-save flag |
| ptr_hi | output | 2 | Upper data-pointer field |

## Verification
The bench goes after each wrap boundary. These are F to 0 on increment, 0 to F on decrement, the RAM increment that lands on 0 and the RAM decrement that lands on F. A design with the wrong compare would skip one step early or never. Add-with-carry is run with carry set and no overflow, where carry must clear. A design that only ever sets carry would leave it high. Plain add is run with carry set, where carry must survive. For the pointer-toggling load and exchange, the bench fills the old and new banks with different values. A design that addressed RAM after the toggle would return the wrong nibble and corrupt the other bank. Unlisted opcodes placed next to real ones, and a disabled cycle, must leave RAM and all registers untouched.

// File: rtl/nx_pkg.sv
package nx_pkg;

    // Default widths of the working registers
    localparam int NIB_W = 4;
    localparam int BANK_W = 2;

    // Operation classes produced by the decoder
    typedef enum logic [4:0] {
        OPC_NONE,
        OPC_LDI,
        OPC_CPL,
        OPC_NEG,
        OPC_INCA,
        OPC_DECA,
        OPC_CLRC,
        OPC_SETC,
        OPC_SWPC,
        OPC_ROTR,
        OPC_INCM,
        OPC_DECM,
        OPC_ADDM,
        OPC_ADDCS,
        OPC_ADDC,
        OPC_ADJ6,
        OPC_ADJA,
        OPC_XORM,
        OPC_STOR,
        OPC_LOADM,
        OPC_XCHM
    } op_e;

endpackage

// File: rtl/nx_decode.sv
module nx_decode
    import nx_pkg::*;
#(
    parameter int DW  = NIB_W,
    parameter int PHW = BANK_W
) (
    input  logic [7:0]     opc_i,
    output op_e            cls_o,
    output logic [DW-1:0]  imm_o,
    output logic [PHW-1:0] bank_x_o
);

    always_comb begin
        imm_o    = opc_i[DW-1:0];
        bank_x_o = opc_i[PHW-1:0];
        cls_o    = OPC_NONE;
        casez (opc_i)
            8'b1001_????: cls_o = OPC_LDI;
            8'h10:        cls_o = OPC_CPL;
            8'h11:        cls_o = OPC_NEG;
            8'h0D:        cls_o = OPC_INCA;
            8'h0F:        cls_o = OPC_DECA;
            8'h0B:        cls_o = OPC_CLRC;
            8'h1B:        cls_o = OPC_SETC;
            8'h1A:        cls_o = OPC_SWPC;
            8'h30:        cls_o = OPC_ROTR;
            8'h1D:        cls_o = OPC_INCM;
            8'h1F:        cls_o = OPC_DECM;
            8'h08:        cls_o = OPC_ADDM;
            8'h09:        cls_o = OPC_ADDCS;
            8'h19:        cls_o = OPC_ADDC;
            8'h06:        cls_o = OPC_ADJ6;
            8'h0A:        cls_o = OPC_ADJA;
            8'h18:        cls_o = OPC_XORM;
            8'h02:        cls_o = OPC_STOR;
            8'b0011_10??: cls_o = OPC_LOADM;
            8'b0010_10??: cls_o = OPC_XCHM;
            default:      cls_o = OPC_NONE;
        endcase
    end

endmodule

// File: rtl/nx_adder.sv
module nx_adder
    import nx_pkg::*;
#(
    parameter int DW = NIB_W
) (
    input  op_e           cls_i,
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] mem_i,
    input  logic          cy_i,
    output logic [DW-1:0] sum_o,
    output logic          cout_o
);

    localparam logic [DW-1:0] ADJ_UP = DW'(6);
    localparam logic [DW-1:0] ADJ_DN = DW'(10);
    localparam logic [DW-1:0] ONES   = {DW{1'b1}};

    logic [DW-1:0] op_a;
    logic [DW-1:0] op_b;
    logic          op_c;
    logic [DW:0]   wide;

    // One shared adder; each class only picks its operands
    always_comb begin
        op_a = acc_i;
        op_b = '0;
        op_c = 1'b0;
        unique case (cls_i)
            OPC_INCA:  begin op_a = acc_i;  op_c = 1'b1; end
            OPC_DECA:  begin op_a = acc_i;  op_b = ONES; end
            OPC_INCM:  begin op_a = mem_i;  op_c = 1'b1; end
            OPC_DECM:  begin op_a = mem_i;  op_b = ONES; end
            OPC_ADDM:  begin op_b = mem_i; end
            OPC_ADDCS: begin op_b = mem_i; op_c = cy_i; end
            OPC_ADDC:  begin op_b = mem_i; op_c = cy_i; end
            OPC_ADJ6:  begin op_b = ADJ_UP; end
            OPC_ADJA:  begin op_b = ADJ_DN; end
            OPC_NEG:   begin op_a = ~acc_i; op_c = 1'b1; end
            default:   begin op_a = acc_i; end
        endcase
    end

    assign wide   = {1'b0, op_a} + {1'b0, op_b} + {{DW{1'b0}}, op_c};
    assign sum_o  = wide[DW-1:0];
    assign cout_o = wide[DW];

endmodule

// File: rtl/nib_exec_unit.sv
module nib_exec_unit
    import nx_pkg::*;
#(
    parameter int DW  = NIB_W,
    parameter int PHW = BANK_W,
    parameter int PLW = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               exec_en,
    input  logic [7:0]         opcode,
    input  logic [PLW-1:0]     ptr_lo,
    input  logic [DW-1:0]      ram_rd,
    output logic [PHW+PLW-1:0] ram_addr,
    output logic               ram_we,
    output logic [DW-1:0]      ram_wdata,
    output logic               skip,
    output logic [DW-1:0]      acc,
    output logic               carry,
    output logic               carry_save,
    output logic [PHW-1:0]     ptr_hi
);

    localparam logic [DW-1:0] ALL_ONES = {DW{1'b1}};

    typedef struct packed {
        logic [DW-1:0]  acc;
        logic           cy;
        logic           cs;
        logic [PHW-1:0] bank;
    } regs_t;

    regs_t regs_q;
    regs_t regs_d;

    op_e            cls;
    logic [DW-1:0]  imm;
    logic [PHW-1:0] bank_x;
    logic [DW-1:0]  sum;
    logic           cout;
    logic           we_d;
    logic [DW-1:0]  wd_d;
    logic           sk_d;

    nx_decode #(.DW(DW), .PHW(PHW)) u_dec (
        .opc_i    (opcode),
        .cls_o    (cls),
        .imm_o    (imm),
        .bank_x_o (bank_x)
    );

    nx_adder #(.DW(DW)) u_add (
        .cls_i  (cls),
        .acc_i  (regs_q.acc),
        .mem_i  (ram_rd),
        .cy_i   (regs_q.cy),
        .sum_o  (sum),
        .cout_o (cout)
    );

    // Next-state and strobe computation
    always_comb begin
        regs_d = regs_q;
        we_d   = 1'b0;
        wd_d   = regs_q.acc;
        sk_d   = 1'b0;
        if (exec_en) begin
            unique case (cls)
                OPC_LDI:  regs_d.acc = imm;
                OPC_CPL:  regs_d.acc = ~regs_q.acc;
                OPC_NEG:  regs_d.acc = sum;
                OPC_INCA: begin
                    regs_d.acc = sum;
                    sk_d       = cout;
                end
                OPC_DECA: begin
                    regs_d.acc = sum;
                    sk_d       = ~cout;
                end
                OPC_CLRC: regs_d.cy = 1'b0;
                OPC_SETC: regs_d.cy = 1'b1;
                OPC_SWPC: begin
                    regs_d.cy = regs_q.cs;
                    regs_d.cs = regs_q.cy;
                end
                OPC_ROTR: begin
                    regs_d.acc = {regs_q.cy, regs_q.acc[DW-1:1]};
                    regs_d.cy  = regs_q.acc[0];
                end
                OPC_INCM: begin
                    we_d = 1'b1;
                    wd_d = sum;
                    sk_d = (sum == '0);
                end
                OPC_DECM: begin
                    we_d = 1'b1;
                    wd_d = sum;
                    sk_d = (sum == ALL_ONES);
                end
                OPC_ADDM: begin
                    regs_d.acc = sum;
                    sk_d       = cout;
                end
                OPC_ADDCS: begin
                    regs_d.acc = sum;
                    regs_d.cy  = cout;
                    sk_d       = cout;
                end
                OPC_ADDC: begin
                    regs_d.acc = sum;
                    regs_d.cy  = cout;
                end
                OPC_ADJ6: regs_d.acc = sum;
                OPC_ADJA: regs_d.acc = sum;
                OPC_XORM: regs_d.acc = regs_q.acc ^ ram_rd;
                OPC_STOR: begin
                    we_d = 1'b1;
                    wd_d = regs_q.acc;
                end
                OPC_LOADM: begin
                    regs_d.acc  = ram_rd;
                    regs_d.bank = regs_q.bank ^ bank_x;
                end
                OPC_XCHM: begin
                    regs_d.acc  = ram_rd;
                    regs_d.bank = regs_q.bank ^ bank_x;
                    we_d        = 1'b1;
                    wd_d        = regs_q.acc;
                end
                default: regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else if (exec_en) begin
            regs_q <= regs_d;
        end
    end

    assign ram_addr   = {regs_q.bank, ptr_lo};
    assign ram_we     = we_d;
    assign ram_wdata  = wd_d;
    assign skip       = sk_d;
    assign acc        = regs_q.acc;
    assign carry      = regs_q.cy;
    assign carry_save = regs_q.cs;
    assign ptr_hi     = regs_q.bank;

endmodule

// File: rtl/nx_exec_chk.sv
module nx_exec_chk #(
    parameter int DW  = 4,
    parameter int PHW = 2
) (
    input logic           clk,
    input logic           rst,
    input logic           exec_en,
    input logic [7:0]     opcode,
    input logic [DW-1:0]  ram_rd,
    input logic           ram_we,
    input logic [DW-1:0]  ram_wdata,
    input logic           skip,
    input logic [DW-1:0]  acc,
    input logic           carry,
    input logic           carry_save,
    input logic [PHW-1:0] ptr_hi
);

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (acc == '0 && !carry && !carry_save && ptr_hi == '0)); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !exec_en |=> ($stable(acc) && $stable(carry) && $stable(carry_save) && $stable(ptr_hi))); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !exec_en |-> (!ram_we && !skip)); // R2

    AST_CARRY_SWAP: assert property (@(posedge clk) disable iff (rst) (exec_en && opcode == 8'h1A) |=> (carry == $past(carry_save) && carry_save == $past(carry))); // R6

    AST_ROT_CARRY: assert property (@(posedge clk) disable iff (rst) (exec_en && opcode == 8'h30) |=> (carry == $past(acc[0]))); // R7

    AST_INCM_SKIP: assert property (@(posedge clk) disable iff (rst) (exec_en && opcode == 8'h1D) |-> (ram_we && skip == (ram_rd == {DW{1'b1}}))); // R8

    AST_STORE_DATA: assert property (@(posedge clk) disable iff (rst) (exec_en && opcode == 8'h02) |-> (ram_we && ram_wdata == acc)); // R12

    AST_BANK_TOGGLE: assert property (@(posedge clk) disable iff (rst) (exec_en && (opcode[7:2] == 6'b001110 || opcode[7:2] == 6'b001010)) |=> (ptr_hi == ($past(ptr_hi) ^ $past(opcode[PHW-1:0])))); // R13

    AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (rst) (exec_en && (opcode == 8'h2C || opcode == 8'h4F)) |-> (!ram_we && !skip)); // R14

endmodule

bind nib_exec_unit nx_exec_chk #(.DW(DW), .PHW(PHW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .exec_en    (exec_en),
    .opcode     (opcode),
    .ram_rd     (ram_rd),
    .ram_we     (ram_we),
    .ram_wdata  (ram_wdata),
    .skip       (skip),
    .acc        (acc),
    .carry      (carry),
    .carry_save (carry_save),
    .ptr_hi     (ptr_hi)
);

// File: tb/nib_exec_unit_tb.sv
module nib_exec_unit_tb;

    localparam int NV = 33;
    localparam logic [3:0] LO = 4'h5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       exec_en = 1'b0;
    logic [7:0] opcode = 8'h00;
    logic [3:0] ptr_lo = LO;
    logic [3:0] ram_rd;
    logic [5:0] ram_addr;
    logic       ram_we;
    logic [3:0] ram_wdata;
    logic       skip;
    logic [3:0] acc;
    logic       carry;
    logic       carry_save;
    logic [1:0] ptr_hi;

    logic [3:0] mem [64];
    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    nib_exec_unit u_dut (
        .clk(clk), .rst(rst), .exec_en(exec_en), .opcode(opcode),
        .ptr_lo(ptr_lo), .ram_rd(ram_rd), .ram_addr(ram_addr),
        .ram_we(ram_we), .ram_wdata(ram_wdata), .skip(skip),
        .acc(acc), .carry(carry), .carry_save(carry_save), .ptr_hi(ptr_hi)
    );

    assign ram_rd = mem[ram_addr];
    always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;

    // {req, op, acc, cy, cs, ram, exp_acc, exp_cy, exp_cs, exp_ram, exp_skip}
    localparam logic [32:0] VEC [NV] = '{
        {4'd3,  8'h9D, 4'h5, 1'b0, 1'b0, 4'h3, 4'hD, 1'b0, 1'b0, 4'h3, 1'b0}, // R3
        {4'd3,  8'h90, 4'h7, 1'b1, 1'b0, 4'h3, 4'h0, 1'b1, 1'b0, 4'h3, 1'b0}, // R3
        {4'd4,  8'h10, 4'h5, 1'b1, 1'b0, 4'h2, 4'hA, 1'b1, 1'b0, 4'h2, 1'b0}, // R4
        {4'd4,  8'h11, 4'h5, 1'b0, 1'b0, 4'h2, 4'hB, 1'b0, 1'b0, 4'h2, 1'b0}, // R4
        {4'd4,  8'h11, 4'h0, 1'b0, 1'b1, 4'h2, 4'h0, 1'b0, 1'b1, 4'h2, 1'b0}, // R4
        {4'd5,  8'h0D, 4'hF, 1'b0, 1'b0, 4'h1, 4'h0, 1'b0, 1'b0, 4'h1, 1'b1}, // R5
        {4'd5,  8'h0D, 4'h7, 1'b1, 1'b0, 4'h1, 4'h8, 1'b1, 1'b0, 4'h1, 1'b0}, // R5
        {4'd5,  8'h0F, 4'h0, 1'b1, 1'b0, 4'h1, 4'hF, 1'b1, 1'b0, 4'h1, 1'b1}, // R5
        {4'd5,  8'h0F, 4'h3, 1'b0, 1'b0, 4'h1, 4'h2, 1'b0, 1'b0, 4'h1, 1'b0}, // R5
        {4'd6,  8'h0B, 4'h4, 1'b1, 1'b0, 4'h0, 4'h4, 1'b0, 1'b0, 4'h0, 1'b0}, // R6
        {4'd6,  8'h1B, 4'h4, 1'b0, 1'b1, 4'h0, 4'h4, 1'b1, 1'b1, 4'h0, 1'b0}, // R6
        {4'd6,  8'h1A, 4'h4, 1'b1, 1'b0, 4'h0, 4'h4, 1'b0, 1'b1, 4'h0, 1'b0}, // R6
        {4'd7,  8'h30, 4'h5, 1'b0, 1'b0, 4'h0, 4'h2, 1'b1, 1'b0, 4'h0, 1'b0}, // R7
        {4'd7,  8'h30, 4'hA, 1'b1, 1'b0, 4'h0, 4'hD, 1'b0, 1'b0, 4'h0, 1'b0}, // R7
        {4'd8,  8'h1D, 4'h2, 1'b1, 1'b0, 4'hF, 4'h2, 1'b1, 1'b0, 4'h0, 1'b1}, // R8
        {4'd8,  8'h1D, 4'h2, 1'b0, 1'b0, 4'h4, 4'h2, 1'b0, 1'b0, 4'h5, 1'b0}, // R8
        {4'd8,  8'h1F, 4'h2, 1'b0, 1'b0, 4'h0, 4'h2, 1'b0, 1'b0, 4'hF, 1'b1}, // R8
        {4'd8,  8'h1F, 4'h2, 1'b1, 1'b0, 4'h9, 4'h2, 1'b1, 1'b0, 4'h8, 1'b0}, // R8
        {4'd9,  8'h08, 4'h9, 1'b0, 1'b0, 4'h8, 4'h1, 1'b0, 1'b0, 4'h8, 1'b1}, // R9
        {4'd9,  8'h08, 4'h3, 1'b1, 1'b0, 4'h4, 4'h7, 1'b1, 1'b0, 4'h4, 1'b0}, // R9
        {4'd10, 8'h09, 4'h9, 1'b1, 1'b0, 4'h6, 4'h0, 1'b1, 1'b0, 4'h6, 1'b1}, // R10
        {4'd10, 8'h09, 4'h2, 1'b1, 1'b0, 4'h3, 4'h6, 1'b0, 1'b0, 4'h3, 1'b0}, // R10
        {4'd10, 8'h19, 4'hF, 1'b1, 1'b0, 4'h0, 4'h0, 1'b1, 1'b0, 4'h0, 1'b0}, // R10
        {4'd10, 8'h19, 4'h4, 1'b1, 1'b0, 4'h4, 4'h9, 1'b0, 1'b0, 4'h4, 1'b0}, // R10
        {4'd11, 8'h06, 4'hC, 1'b0, 1'b0, 4'h0, 4'h2, 1'b0, 1'b0, 4'h0, 1'b0}, // R11
        {4'd11, 8'h0A, 4'h9, 1'b1, 1'b0, 4'h0, 4'h3, 1'b1, 1'b0, 4'h0, 1'b0}, // R11
        {4'd12, 8'h18, 4'hC, 1'b0, 1'b0, 4'h6, 4'hA, 1'b0, 1'b0, 4'h6, 1'b0}, // R12
        {4'd12, 8'h02, 4'h7, 1'b0, 1'b0, 4'h1, 4'h7, 1'b0, 1'b0, 4'h7, 1'b0}, // R12
        {4'd13, 8'h38, 4'h1, 1'b0, 1'b0, 4'hE, 4'hE, 1'b0, 1'b0, 4'hE, 1'b0}, // R13
        {4'd13, 8'h28, 4'h1, 1'b0, 1'b0, 4'hE, 4'hE, 1'b0, 1'b0, 4'h1, 1'b0}, // R13
        {4'd14, 8'h2C, 4'h6, 1'b1, 1'b1, 4'h5, 4'h6, 1'b1, 1'b1, 4'h5, 1'b0}, // R14
        {4'd14, 8'h4F, 4'h6, 1'b1, 1'b1, 4'hF, 4'h6, 1'b1, 1'b1, 4'hF, 1'b0}, // R14
        {4'd14, 8'hC3, 4'h6, 1'b0, 1'b1, 4'h0, 4'h6, 1'b0, 1'b1, 4'h0, 1'b0}  // R14
    };

    task automatic chk(input string tag, input string what, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, actual, expected);
        end
    endtask

    // Drive one opcode; returns the skip strobe seen before the edge
    task automatic run_op(input logic [7:0] op, input logic en, output logic sk);
        @(negedge clk);
        opcode  = op;
        exec_en = en;
        #2;
        sk = skip;
        @(posedge clk);
        #1;
        exec_en = 1'b0;
    endtask

    task automatic preset(input logic [3:0] a, input logic c, input logic s, input logic [3:0] m);
        logic sk;
        run_op(s ? 8'h1B : 8'h0B, 1'b1, sk);
        run_op(8'h1A, 1'b1, sk);
        run_op(8'h90 | {4'h0, m}, 1'b1, sk);
        run_op(8'h02, 1'b1, sk);
        run_op(8'h90 | {4'h0, a}, 1'b1, sk);
        run_op(c ? 8'h1B : 8'h0B, 1'b1, sk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic sk;
        for (int i = 0; i < 64; i++) mem[i] = 4'h0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1", "acc", acc, 0);
        chk("R1", "carry", carry, 0);
        chk("R1", "csave", carry_save, 0);
        chk("R1", "ptr_hi", ptr_hi, 0);
        @(negedge clk);
        rst = 1'b0;

        // Vector table
        for (int i = 0; i < NV; i++) begin
            automatic logic [32:0] v = VEC[i];
            automatic string tag = $sformatf("R%0d vec%0d", v[32:29], i);
            preset(v[20:17], v[16], v[15], v[14:11]);
            run_op(v[28:21], 1'b1, sk);
            chk(tag, "skip", sk, v[0]);
            chk(tag, "acc", acc, v[10:7]);
            chk(tag, "carry", carry, v[6]);
            chk(tag, "csave", carry_save, v[5]);
            chk(tag, "ram", mem[{2'b00, LO}], v[4:1]);
            chk(tag, "ptr_hi", ptr_hi, 0);
        end

        // R2: disabled cycle with a writing opcode on a wrapping nibble
        preset(4'h3, 1'b1, 1'b0, 4'hF);
        run_op(8'h1D, 1'b0, sk);
        chk("R2", "skip", sk, 0);
        chk("R2", "ram", mem[{2'b00, LO}], 4'hF);
        chk("R2", "acc", acc, 3);
        chk("R2", "carry", carry, 1);
        run_op(8'h9A, 1'b0, sk);
        chk("R2", "acc_hold", acc, 3);

        // R13: load uses the old bank, then toggles
        mem[{2'b00, LO}] = 4'h9;
        mem[{2'b11, LO}] = 4'h4;
        run_op(8'h90, 1'b1, sk);
        run_op(8'h3B, 1'b1, sk);
        chk("R13", "acc", acc, 9);
        chk("R13", "ptr_hi", ptr_hi, 3);
        run_op(8'h2A, 1'b1, sk);
        chk("R13", "acc_x", acc, 4);
        chk("R13", "ram_bank3", mem[{2'b11, LO}], 9);
        chk("R13", "ram_bank0", mem[{2'b00, LO}], 9);
        chk("R13", "ptr_hi_x", ptr_hi, 1);

        // R1: reset in the middle of a run
        run_op(8'h1B, 1'b1, sk);
        run_op(8'h1A, 1'b1, sk);
        run_op(8'h97, 1'b1, sk);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk("R1", "acc_mid", acc, 0);
        chk("R1", "csave_mid", carry_save, 0);
        chk("R1", "ptr_hi_mid", ptr_hi, 0);
        chk("R1", "we_mid", ram_we, 0);

        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule